// File: doc/BRIEF.md
# Hold-Latch Scan Register Bank for Two-Pattern Delay Test

This block holds the state flip-flops of a sequential circuit as a serial scan chain. A hold stage sits between each scan cell and the combinational logic, and a small sequencer drives a two-pattern path delay test. The hold stage is either transparent, so the logic sees the scan cell, or holding, so the logic sees a frozen copy. While the stage holds the first state, the chain is free to shift in the second state. Because of this, any pair of states can be launched into the logic, whether or not the logic could produce one from the other.

A test starts with a one-cycle pulse on `start_i`, with the serial data on `scan_in_i`. The sequencer shifts the first state in with the stage transparent, and then freezes that state at the logic. It shifts the second state in behind the frozen copy. It then releases the stage so that the second state reaches the logic, and flags that cycle so that the second input vector is applied at the same moment. Exactly one clock later, the cells load the functional next state. The captured word is unloaded serially during the first shift phase of the next test. Outside a test, the bank acts as an ordinary register: it either loads the functional next state or shifts, and a manual hold control freezes the logic side.

Top module: `dft_hold_scan`

## Requirements
- R1: After reset, `state_o` and `scan_out_o` are all zero, and `launch_o`, `done_o` and `err_o` are low.
- R2: When idle with `scan_en_i` high, each clock moves `scan_in_i` into cell 0 and moves cell i into cell i+1. `scan_out_o` is cell CHAIN_LEN-1, and `state_o` shows the cells.
- R3: When idle with `scan_en_i` and `hold_i` low, each clock loads `func_next_i` into the cells, and `state_o` shows the new value after that edge.
- R4: When idle, the edge that samples `hold_i` high freezes `state_o` at the cell value written at that edge, even though the cells keep changing. The edge that samples `hold_i` low makes `state_o` show the cells again.
- R5: The edge that samples `start_i` in idle performs the first of CHAIN_LEN shifts. The first bit presented ends in cell CHAIN_LEN-1 and the last bit presented ends in cell 0. The hold stage is transparent during these shifts.
- R6: From the edge of the last first-phase shift, `state_o` holds the first state for CHAIN_LEN cycles while a second state is shifted in. `launch_o` is low during this time.
- R7: The edge of the last second-phase shift makes `state_o` equal to the second state. `launch_o` is high for exactly that one following cycle.
- R8: At the edge that ends the launch cycle, the cells load `func_next_i`. `done_o` is then high for exactly one cycle, and the bank returns to idle.
- R9: During the shift edges of the next test's first phase, `scan_out_o` presents the captured word from cell CHAIN_LEN-1 down to cell 0, one bit per cycle.
- R10: A `start_i` sampled while a test runs raises `err_o` for the next cycle. It leaves the running sequence and its results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_in_i | input | 1 | Serial data into cell 0 |
| scan_en_i | input | 1 | Idle-time shift request |
| hold_i | input | 1 | Idle-time hold request for the logic-side stage |
| start_i | input | 1 | Starts a two-pattern test sequence |
| func_next_i | input | CHAIN_LEN | Next state from the combinational logic |
| state_o | output | CHAIN_LEN | Present state presented to the logic |
| scan_out_o | output | 1 | Serial data from cell CHAIN_LEN-1 |
| launch_o | output | 1 | Cycle in which the second input vector is applied |
| done_o | output | 1 | One-cycle pulse after capture |
| err_o | output | 1 | Start received while busy |

## Verification
On every cycle, the embedded properties check that a holding stage never lets `state_o` move. They also check that the stage is holding throughout the second shift phase and transparent in the launch cycle, that launch, done and error are single pulses in their proper order, and that each shift takes the serial input into cell 0. Only the bench scenarios can show that whole words arrive intact. In the scenarios, the frozen word is the first state, the launched word is the second state, and the captured word comes back in order through the following scan-in. The scenarios also cover the functional mode and the manual hold in idle, and show that a late start disturbs none of these words.

// File: rtl/dft_hold_pkg.sv
package dft_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD1  = 2'd1,
    ST_LOAD2  = 2'd2,
    ST_LAUNCH = 2'd3
  } seq_st_e;
endpackage

// File: rtl/scan_cells.sv
module scan_cells #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 scan_in_i,
  input  logic [CHAIN_LEN-1:0] func_i,
  output logic [CHAIN_LEN-1:0] cells_o,
  output logic [CHAIN_LEN-1:0] cells_nxt_o,
  output logic                 scan_out_o
);
  logic [CHAIN_LEN-1:0] cell_q;

  assign cells_nxt_o[0] = shift_i ? scan_in_i : func_i[0];
  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_cell
    assign cells_nxt_o[i] = shift_i ? cell_q[i-1] : func_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cell_q <= '0;
    else         cell_q <= cells_nxt_o;
  end

  assign cells_o    = cell_q;
  assign scan_out_o = cell_q[CHAIN_LEN-1];

  p_shift_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> cell_q[0] == $past(scan_in_i));
  p_shift_tail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> cell_q[CHAIN_LEN-1] == $past(cell_q[CHAIN_LEN-2]));
endmodule

// File: rtl/hold_bank.sv
module hold_bank #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hold_i,
  input  logic [CHAIN_LEN-1:0] cells_i,
  input  logic [CHAIN_LEN-1:0] cells_nxt_i,
  output logic [CHAIN_LEN-1:0] state_o
);
  logic [CHAIN_LEN-1:0] held_q;

  // stored copy tracks the cells while transparent, so the freeze edge keeps the new value
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      held_q[i] <= 1'b0;
      else if (!hold_i) held_q[i] <= cells_nxt_i[i];
    end
    assign state_o[i] = hold_i ? held_q[i] : cells_i[i];
  end

  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> $stable(state_o));
  p_freeze_seamless_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i) |=> (hold_i -> state_o == $past(cells_nxt_i)));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import dft_hold_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scan_en_i,
  input  logic hold_i,
  output logic shift_o,
  output logic hold_o,
  output logic launch_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             done_q, err_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_LOAD1;
        cnt_d = CNT_W'(1);  // start edge is the first shift
      end
      ST_LOAD1: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          st_d  = ST_LOAD2;
          cnt_d = '0;
        end
      end
      ST_LOAD2: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          st_d  = ST_LAUNCH;
          cnt_d = '0;
        end
      end
      ST_LAUNCH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_LOAD2: hold_d = 1'b1;
      ST_IDLE:  hold_d = hold_i;
      default:  hold_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      done_q <= (st_q == ST_LAUNCH);
      err_q  <= start_i && (st_q != ST_IDLE);
    end
  end

  assign shift_o  = (st_q == ST_IDLE) ? (start_i || scan_en_i)
                                      : (st_q == ST_LOAD1 || st_q == ST_LOAD2);
  assign hold_o   = hold_q;
  assign launch_o = (st_q == ST_LAUNCH);
  assign done_o   = done_q;
  assign err_o    = err_q;

  p_hold_in_load2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD2) |-> hold_q);
  p_launch_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (!hold_q && !shift_o));
  p_launch_then_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> (done_o && !launch_o));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q != ST_IDLE) |=> (err_o && st_q != ST_IDLE || done_o));
  p_load1_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD1) |-> (!hold_q && shift_o));
endmodule

// File: rtl/dft_hold_scan.sv
module dft_hold_scan #(
  parameter int unsigned CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scan_in_i,
  input  logic                 scan_en_i,
  input  logic                 hold_i,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] func_next_i,
  output logic [CHAIN_LEN-1:0] state_o,
  output logic                 scan_out_o,
  output logic                 launch_o,
  output logic                 done_o,
  output logic                 err_o
);
  logic                 shift, hold;
  logic [CHAIN_LEN-1:0] cells, cells_nxt;

  seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .scan_en_i (scan_en_i),
    .hold_i    (hold_i),
    .shift_o   (shift),
    .hold_o    (hold),
    .launch_o  (launch_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  scan_cells #(.CHAIN_LEN(CHAIN_LEN)) u_cells (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (shift),
    .scan_in_i   (scan_in_i),
    .func_i      (func_next_i),
    .cells_o     (cells),
    .cells_nxt_o (cells_nxt),
    .scan_out_o  (scan_out_o)
  );

  hold_bank #(.CHAIN_LEN(CHAIN_LEN)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold),
    .cells_i     (cells),
    .cells_nxt_i (cells_nxt),
    .state_o     (state_o)
  );

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> cells == $past(func_next_i));
endmodule

// File: tb/dft_hold_scan_test.sv
module dft_hold_scan_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_in = 1'b0, scan_en = 1'b0, hold = 1'b0, start = 1'b0;
  logic [N-1:0] func_next = '0;
  logic [N-1:0] state;
  logic         scan_out, launch, done, err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  dft_hold_scan #(.CHAIN_LEN(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scan_in_i(scan_in), .scan_en_i(scan_en),
    .hold_i(hold), .start_i(start), .func_next_i(func_next),
    .state_o(state), .scan_out_o(scan_out), .launch_o(launch),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input logic ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] rnd_word();
    return N'($urandom);
  endfunction

  // called right after a negedge in idle; cells hold prev
  task automatic run_seq(input logic [N-1:0] s1, input logic [N-1:0] s2,
                         input logic [N-1:0] fn, input logic [N-1:0] prev,
                         input int err_at);
    for (int k = 0; k < N; k++) begin
      chk(scan_out == prev[N-1-k], "R9 unload order", N'(scan_out), N'(prev[N-1-k]));
      start   = (k == 0);
      scan_in = s1[N-1-k];
      @(negedge clk);
    end
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      chk(state == s1, "R6 first state held", state, s1);
      chk(!launch, "R6 no launch in second shift", N'(launch), '0);
      chk(scan_out == s1[N-1-k], "R5 first state order", N'(scan_out), N'(s1[N-1-k]));
      if (k > 0 && err_at == k - 1) chk(err, "R10 err pulse", N'(err), N'(1));
      start   = (k == err_at);
      scan_in = s2[N-1-k];
      @(negedge clk);
    end
    start = 1'b0;
    if (err_at == N - 1) chk(err, "R10 err pulse", N'(err), N'(1));
    chk(state == s2, "R7 second state launched", state, s2);
    chk(launch, "R7 launch flag", N'(launch), N'(1));
    chk(!done, "R8 no early done", N'(done), '0);
    func_next = fn;
    @(negedge clk);
    chk(done, "R8 done pulse", N'(done), N'(1));
    chk(!launch, "R7 launch single cycle", N'(launch), '0);
    chk(state == fn, "R8 capture", state, fn);
    chk(!err, "R10 no spurious err", N'(err), '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [N-1:0] a, b, p, prev;
    void'($urandom(32'h5eed_0123));
    #1;
    chk(state == '0 && scan_out == 1'b0 && !launch && !done && !err,
        "R1 reset", state, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == '0, "R1 reset hold after release", state, '0);

    // R3 functional load
    for (int i = 0; i < 3; i++) begin
      a = rnd_word();
      func_next = a;
      @(negedge clk);
      chk(state == a, "R3 functional load", state, a);
    end

    // R4 manual hold
    a = rnd_word();
    b = ~a;
    func_next = a;
    @(negedge clk);
    hold = 1'b1;
    @(negedge clk);
    func_next = b;
    @(negedge clk);
    chk(state == a, "R4 frozen under hold", state, a);
    @(negedge clk);
    chk(state == a, "R4 still frozen", state, a);
    hold = 1'b0;
    @(negedge clk);
    chk(state == b, "R4 release shows cells", state, b);

    // R2 manual shift
    p = rnd_word();
    scan_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      scan_in = p[N-1-k];
      @(negedge clk);
    end
    chk(state == p, "R2 idle shift word", state, p);
    chk(scan_out == p[N-1], "R2 scan out tail", N'(scan_out), N'(p[N-1]));
    scan_en = 1'b0;
    prev = rnd_word();
    func_next = prev;
    @(negedge clk);

    // directed corners
    run_seq('1, '0, 8'hA5, prev, -1);
    prev = 8'hA5;
    run_seq('0, '1, 8'h5A, prev, -1);
    prev = 8'h5A;
    run_seq(8'h81, 8'h7E, 8'h3C, prev, 2);      // R10 mid second phase
    prev = 8'h3C;
    run_seq(8'hC3, 8'h3C, 8'hF0, prev, N - 1);  // R10 in last shift
    prev = 8'hF0;

    // random back-to-back tests
    for (int t = 0; t < 20; t++) begin
      a = rnd_word();
      b = rnd_word();
      p = rnd_word();
      run_seq(a, b, p, prev, -1);
      prev = p;
      if (t % 4 == 3) @(negedge clk);  // idle gap keeps capture with steady func
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule